// File: doc/BRIEF.md
# Dual Full-Match Alarm Unit

This block watches a BCD calendar time that is kept elsewhere and compares it against two independent alarm time sets. Each set holds seconds, minutes, hours, day, month and year. An alarm matches only when all six fields equal the running time; no field can be masked. The compare runs once per one-second strobe, sampled after the time keeper has updated its fields. A match sets a sticky status flag, which software clears by writing a one to it.

The first alarm produces a level interrupt and, if enabled, a wake request. The second alarm can also produce an interrupt. Its main use is to shut down an external power-management chip: when power control is enabled, a match drops `pmic_power_en` to its off level. The pin stays off until the block is reset. A small word-addressed register port holds the alarm times and the enables. A combinational read port returns any register.

Top module: `dual_alarm_unit`

## Requirements
- R1: Alarm 1 fields sit at offsets 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and alarm 2 fields at 0x80, 0x84, 0x88, 0x8C, 0x90, 0x94. In both sets the field order is seconds, minutes, hours, day, month, year. A write stores the low 8 bits of `wr_data`, and a read returns them with all upper bits zero.
- R2: When `tick_1s` is high at a clock edge and all six current fields equal an alarm's fields, that alarm's flag reads as set from the next cycle. Flags are at offset 0x44: bit 6 is alarm 1 and bit 7 is alarm 2.
- R3: If any single field differs from the alarm's value, a tick does not set the flag.
- R4: A matching time without `tick_1s` never sets a flag.
- R5: Writing 0x44 with a one in bit 6 or bit 7 clears that flag. Zero bits leave flags unchanged. If a set and a clear land on the same edge, the set wins.
- R6: `irq_alarm` is high while (alarm 1 flag and enable bit 3) or (alarm 2 flag and enable bit 4). The enable register is at 0x48 and reads back bits 3 and 4.
- R7: `wake` is high while the alarm 1 flag and bit 1 of the wake-enable register at 0x7C are both set. Alarm 2 never drives `wake`.
- R8: `pmic_power_en` is 1 after reset. When bit 16 of the power register at 0x98 is set, an alarm 2 match drives the pin to 0 in the cycle after the tick. The pin then stays 0, even after the flag is cleared or bit 16 is dropped, until reset.
- R9: With bit 16 of 0x98 clear, an alarm 2 match sets its flag but leaves `pmic_power_en` at 1.
- R10: After reset, flags, enables and alarm fields read 0, `irq_alarm` and `wake` are 0, and `pmic_power_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle strobe after each time update |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data, combinational |
| irq_alarm | output | 1 | Level interrupt from enabled flags |
| wake | output | 1 | Wake request from alarm 1 |
| pmic_power_en | output | 1 | External power enable, 1 = on |

## Verification
A wrong stored alarm field or a broken comparator shows up one cycle after the matching tick: the flag does not appear in the status read and `irq_alarm` stays low. A flag that sets without a tick, or that fails to clear, also appears at the status read in the next cycle and at `irq_alarm` or `wake` in the same cycle. A power latch that reopens is visible on `pmic_power_en` one cycle after the status write that clears the flag. Since that latch holds until reset, a single wrong drop stays visible for the rest of the run.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;

  // number of calendar fields held per alarm set, seconds first
  localparam int unsigned NUM_FIELDS = 6;
  // spacing of consecutive field registers in the offset space
  localparam int unsigned FIELD_STRIDE = 4;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DAY   = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5
  } field_e;

  // offset of field idx within a set starting at base
  function automatic logic [31:0] field_addr(input logic [31:0] base, input int unsigned idx);
    return base + 32'(idx * FIELD_STRIDE);
  endfunction

  // true when addr selects field idx of the set at base
  function automatic logic field_sel(input logic [31:0] addr, input logic [31:0] base,
                                     input int unsigned idx);
    return addr == field_addr(base, idx);
  endfunction

  // next value of a sticky write-one-to-clear flag; a new event beats a clear
  function automatic logic sticky_next(input logic cur, input logic set_ev, input logic clr);
    return set_ev | (cur & ~clr);
  endfunction

endpackage

// File: rtl/dual_alarm_bank.sv
module dual_alarm_bank #(
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned NUM_FIELDS = dual_alarm_pkg::NUM_FIELDS,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [31:0] BASE       = 32'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic [NUM_FIELDS*FIELD_W-1:0] now_time,
  output logic [NUM_FIELDS*FIELD_W-1:0] alarm_time,
  output logic                          hit
);
  import dual_alarm_pkg::*;

  localparam int unsigned TIME_W = NUM_FIELDS * FIELD_W;

  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] val_q;
    logic               sel;

    assign sel = wr_en && field_sel(32'(wr_addr), BASE, g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (sel) val_q <= wr_data;
    end

    assign alarm_time[g*FIELD_W +: FIELD_W] = val_q;
    assign field_eq[g] = (val_q == now_time[g*FIELD_W +: FIELD_W]);
  end

  // every field must agree; there is no per-field mask
  assign hit = &field_eq;

  logic [TIME_W-1:0] unused_width_probe;
  assign unused_width_probe = '0;

endmodule

// File: rtl/dual_alarm_flags.sv
module dual_alarm_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  import dual_alarm_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= sticky_next(flags[g], set_ev[g], clr_req[g]);
    end
  end

endmodule

// File: rtl/dual_alarm_pwr.sv
module dual_alarm_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_en,
  input  logic off_ev,
  output logic power_en
);
  logic off_q;

  // once off, only reset brings the supply back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_q <= 1'b0;
    else if (ctl_en && off_ev)  off_q <= 1'b1;
  end

  assign power_en = ~off_q;

endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter logic [31:0] A1_BASE     = 32'h20,
  parameter logic [31:0] A2_BASE     = 32'h80,
  parameter logic [31:0] STATUS_ADDR = 32'h44,
  parameter logic [31:0] IE_ADDR     = 32'h48,
  parameter logic [31:0] WAKE_ADDR   = 32'h7C,
  parameter logic [31:0] PWR_ADDR    = 32'h98,
  parameter int unsigned FLAG1_BIT   = 6,
  parameter int unsigned FLAG2_BIT   = 7,
  parameter int unsigned IE1_BIT     = 3,
  parameter int unsigned IE2_BIT     = 4,
  parameter int unsigned WAKE_BIT    = 1,
  parameter int unsigned PWR_BIT     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hour,
  input  logic [FIELD_W-1:0] now_day,
  input  logic [FIELD_W-1:0] now_month,
  input  logic [FIELD_W-1:0] now_year,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_alarm,
  output logic              wake,
  output logic              pmic_power_en
);
  import dual_alarm_pkg::*;

  localparam int unsigned NF     = NUM_FIELDS;
  localparam int unsigned TIME_W = NF * FIELD_W;
  localparam int unsigned N_ALM  = 2;

  logic [TIME_W-1:0] now_time;
  logic [TIME_W-1:0] a1_time, a2_time;
  logic              hit1, hit2;
  logic              ev1, ev2;
  logic              clr1, clr2;
  logic [N_ALM-1:0]  flags;
  logic              flag1, flag2;
  logic              ie1_q, ie2_q, wake_en_q, pmic_ctl_q;
  logic              st_wr, ie_wr, wk_wr, pw_wr;

  // field 0 in the low byte, year on top
  assign now_time = {now_year, now_month, now_day, now_hour, now_min, now_sec};

  dual_alarm_bank #(.FIELD_W(FIELD_W), .NUM_FIELDS(NF), .ADDR_W(ADDR_W), .BASE(A1_BASE)) bank1_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data[FIELD_W-1:0]),
    .now_time   (now_time),
    .alarm_time (a1_time),
    .hit        (hit1)
  );

  dual_alarm_bank #(.FIELD_W(FIELD_W), .NUM_FIELDS(NF), .ADDR_W(ADDR_W), .BASE(A2_BASE)) bank2_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data[FIELD_W-1:0]),
    .now_time   (now_time),
    .alarm_time (a2_time),
    .hit        (hit2)
  );

  // named events for the checker: compare qualified by the strobe
  assign ev1 = tick_1s & hit1;
  assign ev2 = tick_1s & hit2;

  assign st_wr = wr_en && (32'(wr_addr) == STATUS_ADDR);
  assign ie_wr = wr_en && (32'(wr_addr) == IE_ADDR);
  assign wk_wr = wr_en && (32'(wr_addr) == WAKE_ADDR);
  assign pw_wr = wr_en && (32'(wr_addr) == PWR_ADDR);

  assign clr1 = st_wr & wr_data[FLAG1_BIT];
  assign clr2 = st_wr & wr_data[FLAG2_BIT];

  dual_alarm_flags #(.N(N_ALM)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  ({ev2, ev1}),
    .clr_req ({clr2, clr1}),
    .flags   (flags)
  );

  assign flag1 = flags[0];
  assign flag2 = flags[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie1_q      <= 1'b0;
      ie2_q      <= 1'b0;
      wake_en_q  <= 1'b0;
      pmic_ctl_q <= 1'b0;
    end else begin
      if (ie_wr) begin
        ie1_q <= wr_data[IE1_BIT];
        ie2_q <= wr_data[IE2_BIT];
      end
      if (wk_wr) wake_en_q  <= wr_data[WAKE_BIT];
      if (pw_wr) pmic_ctl_q <= wr_data[PWR_BIT];
    end
  end

  dual_alarm_pwr pwr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_en   (pmic_ctl_q),
    .off_ev   (ev2),
    .power_en (pmic_power_en)
  );

  assign irq_alarm = (flag1 & ie1_q) | (flag2 & ie2_q);
  assign wake      = flag1 & wake_en_q;

  always_comb begin
    rd_data = '0;
    for (int unsigned i = 0; i < NF; i++) begin
      if (field_sel(32'(rd_addr), A1_BASE, i)) rd_data[FIELD_W-1:0] = a1_time[i*FIELD_W +: FIELD_W];
      if (field_sel(32'(rd_addr), A2_BASE, i)) rd_data[FIELD_W-1:0] = a2_time[i*FIELD_W +: FIELD_W];
    end
    if (32'(rd_addr) == STATUS_ADDR) begin
      rd_data[FLAG1_BIT] = flag1;
      rd_data[FLAG2_BIT] = flag2;
    end
    if (32'(rd_addr) == IE_ADDR) begin
      rd_data[IE1_BIT] = ie1_q;
      rd_data[IE2_BIT] = ie2_q;
    end
    if (32'(rd_addr) == WAKE_ADDR) rd_data[WAKE_BIT] = wake_en_q;
    if (32'(rd_addr) == PWR_ADDR)  rd_data[PWR_BIT]  = pmic_ctl_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

endmodule

// File: rtl/dual_alarm_unit_chk.sv
module dual_alarm_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1s,
  input logic hit1,
  input logic hit2,
  input logic clr1,
  input logic clr2,
  input logic flag1,
  input logic flag2,
  input logic ie1_q,
  input logic ie2_q,
  input logic pmic_ctl_q,
  input logic irq_alarm,
  input logic wake,
  input logic pmic_power_en
);

  assert_set_a1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && hit1) |=> flag1);

  assert_set_a2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && hit2) |=> flag2);

  assert_no_spurious_a1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag1 && !(tick_1s && hit1)) |=> !flag1);

  assert_no_spurious_a2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag2 && !(tick_1s && hit2)) |=> !flag2);

  assert_clear_a1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && !(tick_1s && hit1)) |=> !flag1);

  assert_irq_a1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && ie1_q) |-> irq_alarm);

  assert_irq_a2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2 && ie2_q) |-> irq_alarm);

  assert_wake_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> flag1);

  assert_pwr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pmic_power_en |=> !pmic_power_en);

  assert_pwr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pmic_power_en) |-> $past(tick_1s && hit2 && pmic_ctl_q));

  assert_pwr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pmic_power_en && !pmic_ctl_q) |=> pmic_power_en);

endmodule

bind dual_alarm_unit dual_alarm_unit_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_1s       (tick_1s),
  .hit1          (hit1),
  .hit2          (hit2),
  .clr1          (clr1),
  .clr2          (clr2),
  .flag1         (flag1),
  .flag2         (flag2),
  .ie1_q         (ie1_q),
  .ie2_q         (ie2_q),
  .pmic_ctl_q    (pmic_ctl_q),
  .irq_alarm     (irq_alarm),
  .wake          (wake),
  .pmic_power_en (pmic_power_en)
);

// File: tb/dual_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module dual_alarm_unit_tb_top;

  typedef struct {
    string       req;
    logic [7:0]  addr;
    logic [31:0] exp_data;
    logic        exp_irq;
    logic        exp_wake;
    logic        exp_pwr;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic [7:0]  now_f [6];
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h44;
  logic [31:0] rd_data;
  logic        irq_alarm, wake, pmic_power_en;

  exp_item_t   sb_q [$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // alarm 1 and alarm 2 targets, seconds first
  logic [7:0] a1 [6] = '{8'h45, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24};
  logic [7:0] a2 [6] = '{8'h47, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24};

  always #2.5 clk = ~clk;

  dual_alarm_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_1s       (tick_1s),
    .now_sec       (now_f[0]),
    .now_min       (now_f[1]),
    .now_hour      (now_f[2]),
    .now_day       (now_f[3]),
    .now_month     (now_f[4]),
    .now_year      (now_f[5]),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .irq_alarm     (irq_alarm),
    .wake          (wake),
    .pmic_power_en (pmic_power_en)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      exp_item_t it;
      wait (sb_q.size() != 0);
      it = sb_q[0];
      rd_addr = it.addr;
      #1;
      n_checks++;
      if (rd_data !== it.exp_data || irq_alarm !== it.exp_irq ||
          wake !== it.exp_wake || pmic_power_en !== it.exp_pwr) begin
        n_fail++;
        $display("FAIL %s addr=%h actual data=%h irq=%b wake=%b pwr=%b expected data=%h irq=%b wake=%b pwr=%b",
                 it.req, it.addr, rd_data, irq_alarm, wake, pmic_power_en,
                 it.exp_data, it.exp_irq, it.exp_wake, it.exp_pwr);
      end
      sb_q.delete(0);
    end
  end

  task automatic expect_state(input string req, input logic [7:0] addr, input logic [31:0] d,
                              input logic irq, input logic wk, input logic pw);
    exp_item_t it;
    it.req = req; it.addr = addr; it.exp_data = d;
    it.exp_irq = irq; it.exp_wake = wk; it.exp_pwr = pw;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] t [6]);
    for (int i = 0; i < 6; i++) now_f[i] = t[i];
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] t [6];
    for (int i = 0; i < 6; i++) now_f[i] = 8'h00;
    do_reset();

    // R10 reset state
    expect_state("R10", 8'h44, 32'h0, 1'b0, 1'b0, 1'b1);
    expect_state("R10", 8'h20, 32'h0, 1'b0, 1'b0, 1'b1);
    expect_state("R10", 8'h98, 32'h0, 1'b0, 1'b0, 1'b1);

    // R1 program both sets, check layout and upper-bit drop
    for (int i = 0; i < 6; i++) write_reg(8'(8'h20 + 4*i), 32'(a1[i]));
    for (int i = 0; i < 6; i++) write_reg(8'(8'h80 + 4*i), 32'(a2[i]));
    expect_state("R1", 8'h24, 32'h30, 1'b0, 1'b0, 1'b1);
    expect_state("R1", 8'h34, 32'h24, 1'b0, 1'b0, 1'b1);
    expect_state("R1", 8'h80, 32'h47, 1'b0, 1'b0, 1'b1);
    write_reg(8'h20, 32'hFFFF_FF45);
    expect_state("R1", 8'h20, 32'h45, 1'b0, 1'b0, 1'b1);

    // R4 matching time without strobe
    set_time(a1);
    repeat (4) @(negedge clk);
    expect_state("R4", 8'h44, 32'h0, 1'b0, 1'b0, 1'b1);

    // R3 one field off at a time
    for (int f = 0; f < 6; f++) begin
      t = a1;
      t[f] = t[f] ^ 8'h01;
      set_time(t);
      pulse_tick();
      expect_state("R3", 8'h44, 32'h0, 1'b0, 1'b0, 1'b1);
    end

    // R2 full match on alarm 1
    set_time(a1);
    pulse_tick();
    expect_state("R2", 8'h44, 32'h40, 1'b0, 1'b0, 1'b1);

    // R6 / R7 enables
    write_reg(8'h48, 32'h08);
    expect_state("R6", 8'h48, 32'h08, 1'b1, 1'b0, 1'b1);
    write_reg(8'h7C, 32'h02);
    expect_state("R7", 8'h7C, 32'h02, 1'b1, 1'b1, 1'b1);

    // R5 zero write keeps, one write clears
    write_reg(8'h44, 32'h00);
    expect_state("R5", 8'h44, 32'h40, 1'b1, 1'b1, 1'b1);
    write_reg(8'h44, 32'h40);
    expect_state("R5", 8'h44, 32'h00, 1'b0, 1'b0, 1'b1);

    // R9 alarm 2 with power control off; R7 alarm 2 does not wake
    set_time(a2);
    pulse_tick();
    expect_state("R9", 8'h44, 32'h80, 1'b0, 1'b0, 1'b1);

    // R6 alarm 2 interrupt via bit 4
    write_reg(8'h48, 32'h10);
    expect_state("R6", 8'h44, 32'h80, 1'b1, 1'b0, 1'b1);
    write_reg(8'h44, 32'h80);
    expect_state("R5", 8'h44, 32'h00, 1'b0, 1'b0, 1'b1);

    // R5 set beats simultaneous clear
    set_time(a1);
    @(negedge clk);
    tick_1s = 1'b1; wr_en = 1'b1; wr_addr = 8'h44; wr_data = 32'h40;
    @(negedge clk);
    tick_1s = 1'b0; wr_en = 1'b0;
    expect_state("R5", 8'h44, 32'h40, 1'b0, 1'b1, 1'b1);
    write_reg(8'h44, 32'h40);

    // R8 power-off path
    write_reg(8'h98, 32'h0001_0000);
    expect_state("R8", 8'h98, 32'h0001_0000, 1'b0, 1'b0, 1'b1);
    set_time(a2);
    pulse_tick();
    expect_state("R8", 8'h44, 32'h80, 1'b1, 1'b0, 1'b0);
    write_reg(8'h44, 32'h80);
    expect_state("R8", 8'h44, 32'h00, 1'b0, 1'b0, 1'b0);
    write_reg(8'h98, 32'h0);
    repeat (3) @(negedge clk);
    expect_state("R8", 8'h98, 32'h0, 1'b0, 1'b0, 1'b0);

    // R10 reset restores power
    do_reset();
    expect_state("R10", 8'h44, 32'h0, 1'b0, 1'b0, 1'b1);
    expect_state("R10", 8'h48, 32'h0, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule